// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully-associative store that sits between a direct-mapped first-level cache and the path that refills it. When the direct-mapped array misses, the cache controller presents the full line address as a lookup. In the same cycle it may present the line that the miss displaces on the evicted-line port.

If the buffer holds the requested line, the line is returned one cycle later and its entry is handed to the displaced line, so the two lines trade places. If the buffer does not hold it, the block starts a request to the next memory level and forwards the response when it arrives. The displaced line is stored either way.

Entries carry the full line address as tag plus a valid bit. A fill into a full buffer replaces the entry written least recently. Only one next-level miss is outstanding at a time. While it is pending, the lookup port is not ready, but fills are still accepted.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is invalid, lkp_ready_o is 1, nl_req_o is 0 and rsp_valid_o is 0. The first lookup after reset therefore misses.
- R2: An accepted lookup that finds its address in the buffer gives rsp_valid_o=1 in the next cycle, with rsp_src_o=0 (0 means buffer) and the stored line on rsp_data_o. No next-level request is made.
- R3: When a lookup hits and the evicted-line port carries a different line in the same cycle, that line is written into the hit entry. The requested line leaves the buffer, and a later lookup of it misses.
- R4: A lookup hit with no fill in the same cycle invalidates the hit entry, so a repeated lookup of the same address misses.
- R5: An accepted lookup that misses raises nl_req_o in the next cycle, with nl_addr_o equal to the lookup address. Both hold stable until the cycle in which nl_gnt_i is 1. lkp_ready_o is 0 from the cycle after the lookup until the response is delivered.
- R6: In the cycle after nl_rsp_valid_i is sampled while waiting, rsp_valid_o=1 with rsp_src_o=1 (1 means next level), rsp_data_o equals nl_rsp_data_i, and lkp_ready_o is 1 again.
- R7: A fill whose address is not present, into a buffer that has an invalid entry, takes an invalid entry and evicts nothing.
- R8: A fill whose address is not present, into a full buffer, replaces the entry whose last write is the oldest.
- R9: A fill whose address is already present overwrites that entry in place and makes it the most recently written. No two valid entries ever share an address.
- R10: A lookup and a fill of the same address in the same cycle are resolved in favour of the fill. The lookup hits with the fill data (rsp_src_o=0), and the line is not stored in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request after a direct-mapped miss |
| lkp_addr_i | input | AW | Full line address of the lookup |
| lkp_ready_o | output | 1 | Lookup may be accepted (no miss pending) |
| fill_valid_i | input | 1 | Line evicted from the direct-mapped array |
| fill_addr_i | input | AW | Line address of the evicted line |
| fill_data_i | input | DW | Data of the evicted line |
| rsp_valid_o | output | 1 | Line returned to the cache |
| rsp_src_o | output | 1 | 0: from the buffer, 1: from the next level |
| rsp_data_o | output | DW | Returned line data |
| nl_req_o | output | 1 | Next-level read request |
| nl_addr_o | output | AW | Line address requested from the next level |
| nl_gnt_i | input | 1 | Next level accepts the request |
| nl_rsp_valid_i | input | 1 | Next-level response valid |
| nl_rsp_data_i | input | DW | Next-level response data |

## Verification
A wrong valid bit or tag shows at the ports on the next lookup of that address. A line that should be present instead raises nl_req_o one cycle after the lookup. A line that should be gone instead returns buffer data one cycle after the lookup. A damaged replacement order is invisible until a fill lands in a full buffer; it then shows on the next lookup of the entry that should have survived. The scenarios are therefore arranged so that every write, swap and eviction is followed by lookups that probe both the line that should be kept and the line that should be gone.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } miss_st_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 4,
  parameter int AW      = 26,
  parameter int IW      = 2
) (
  input  logic [ENTRIES-1:0]         valid_i,
  input  logic [ENTRIES-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]              key_i,
  output logic                       hit_o,
  output logic [IW-1:0]              idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  always_comb begin
    hit_o = |eq;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
  parameter int ENTRIES = 4,
  parameter int IW      = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_i,
  input  logic [IW-1:0]      touch_idx_i,
  input  logic [ENTRIES-1:0] valid_i,
  output logic [IW-1:0]      victim_o
);
  // rank 0 = most recently written, ENTRIES-1 = oldest
  logic [ENTRIES-1:0][IW-1:0] rank_q;
  logic [IW-1:0]              touch_rank;
  logic                       free_found;

  assign touch_rank = rank_q[touch_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == touch_idx_i)       rank_q[i] <= '0;
        else if (rank_q[i] < touch_rank) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !free_found) begin
        victim_o   = IW'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_q[i] == IW'(ENTRIES - 1)) victim_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vb_miss_fsm.sv
module vb_miss_fsm
  import vb_pkg::*;
#(
  parameter int AW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          nl_gnt_i,
  input  logic          nl_rsp_valid_i,
  output logic          nl_req_o,
  output logic [AW-1:0] nl_addr_o,
  output logic          idle_o,
  output logic          done_o
);
  miss_st_e      st_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_REQ;
          addr_q <= addr_i;
        end
        ST_REQ:  if (nl_gnt_i) st_q <= ST_WAIT;
        ST_WAIT: if (nl_rsp_valid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign nl_req_o  = (st_q == ST_REQ);
  assign nl_addr_o = addr_q;
  assign idle_o    = (st_q == ST_IDLE);
  assign done_o    = (st_q == ST_WAIT) && nl_rsp_valid_i;
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ENTRIES = 4,   // 1 to 5 lines
  parameter int AW      = 26,  // line address width
  parameter int DW      = 64   // line data width
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lkp_valid_i,
  input  logic [AW-1:0] lkp_addr_i,
  output logic          lkp_ready_o,
  input  logic          fill_valid_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  output logic          rsp_valid_o,
  output logic          rsp_src_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          nl_req_o,
  output logic [AW-1:0] nl_addr_o,
  input  logic          nl_gnt_i,
  input  logic          nl_rsp_valid_i,
  input  logic [DW-1:0] nl_rsp_data_i
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]         valid_q;
  logic [ENTRIES-1:0][AW-1:0] tag_q;
  logic [ENTRIES-1:0][DW-1:0] data_q;

  logic          lm_hit, fm_hit;
  logic [IW-1:0] lm_idx, fm_idx, alloc_idx, tgt_idx;
  logic          lkp_fire, bypass, lkp_hit, hit_any, do_fill, miss_start;
  logic          fsm_idle, fsm_done;

  vb_match #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_lkp_match (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(lkp_addr_i),
    .hit_o(lm_hit), .idx_o(lm_idx)
  );

  vb_match #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_fill_match (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(fill_addr_i),
    .hit_o(fm_hit), .idx_o(fm_idx)
  );

  assign lkp_fire   = lkp_valid_i && lkp_ready_o;
  // same-address fill wins: line goes straight back to the direct-mapped array
  assign bypass     = lkp_fire && fill_valid_i && (lkp_addr_i == fill_addr_i);
  assign lkp_hit    = lkp_fire && lm_hit;
  assign hit_any    = bypass || lkp_hit;
  assign do_fill    = fill_valid_i && !bypass;
  assign miss_start = lkp_fire && !hit_any;

  // in-place update, else swap into the hit entry, else allocate
  assign tgt_idx = fm_hit ? fm_idx : (lkp_hit ? lm_idx : alloc_idx);

  vb_lru #(.ENTRIES(ENTRIES), .IW(IW)) u_lru (
    .clk_i, .rst_ni,
    .touch_i(do_fill), .touch_idx_i(tgt_idx),
    .valid_i(valid_q), .victim_o(alloc_idx)
  );

  vb_miss_fsm #(.AW(AW)) u_miss (
    .clk_i, .rst_ni,
    .start_i(miss_start), .addr_i(lkp_addr_i),
    .nl_gnt_i, .nl_rsp_valid_i,
    .nl_req_o, .nl_addr_o,
    .idle_o(fsm_idle), .done_o(fsm_done)
  );

  assign lkp_ready_o = fsm_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_fill && tgt_idx == IW'(i))      valid_q[i] <= 1'b1;
        else if (lkp_hit && lm_idx == IW'(i))  valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (do_fill && tgt_idx == IW'(i)) begin
        tag_q[i]  <= fill_addr_i;
        data_q[i] <= fill_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_src_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= hit_any || fsm_done;
      if (hit_any) begin
        rsp_src_o  <= 1'b0;
        rsp_data_o <= bypass ? fill_data_i : data_q[lm_idx];
      end else if (fsm_done) begin
        rsp_src_o  <= 1'b1;
        rsp_data_o <= nl_rsp_data_i;
      end
    end
  end
endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
  parameter int ENTRIES = 4,
  parameter int AW      = 26
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       lkp_valid_i,
  input logic                       lkp_ready_o,
  input logic [AW-1:0]              lkp_addr_i,
  input logic                       fill_valid_i,
  input logic [AW-1:0]              fill_addr_i,
  input logic                       rsp_valid_o,
  input logic                       rsp_src_o,
  input logic                       nl_req_o,
  input logic [AW-1:0]              nl_addr_o,
  input logic                       nl_gnt_i,
  input logic                       nl_rsp_valid_i,
  input logic                       hit_any,
  input logic                       bypass,
  input logic [ENTRIES-1:0]         valid_q,
  input logic [ENTRIES-1:0][AW-1:0] tag_q
);
  logic dup;

  function automatic logic present(input logic [AW-1:0] a);
    logic p;
    p = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && tag_q[i] == a) p = 1'b1;
    end
    return p;
  endfunction

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int j = i + 1; j < ENTRIES; j++) begin
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
      end
    end
  end

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i && lkp_ready_o && hit_any |=> rsp_valid_o && !rsp_src_o); // R2
  AST_MISS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i && lkp_ready_o && !hit_any |=> nl_req_o && !lkp_ready_o && nl_addr_o == $past(lkp_addr_i)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_o && !nl_gnt_i |=> nl_req_o && $stable(nl_addr_o)); // R5
  AST_NL_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_ready_o && !nl_req_o && nl_rsp_valid_i |=> rsp_valid_o && rsp_src_o && lkp_ready_o); // R6
  AST_FILL_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && !bypass |=> present($past(fill_addr_i))); // R7
  AST_NO_DUP_TAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup); // R9
  AST_BYPASS_NOT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> !present($past(fill_addr_i))); // R10
endmodule

bind victim_buf victim_buf_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (.*);

// File: tb/tb_victim_buf.sv
`timescale 1ns/1ps
module tb_victim_buf;
  localparam int ENTRIES = 4;
  localparam int AW      = 26;
  localparam int DW      = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lkp_valid = 1'b0;
  logic [AW-1:0] lkp_addr = '0;
  logic          lkp_ready;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          rsp_valid, rsp_src;
  logic [DW-1:0] rsp_data;
  logic          nl_req;
  logic [AW-1:0] nl_addr;
  logic          nl_gnt = 1'b0;
  logic          nl_rv = 1'b0;
  logic [DW-1:0] nl_rd = '0;

  int checks = 0;
  int errors = 0;
  logic [DW:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  victim_buf #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_addr_i(lkp_addr), .lkp_ready_o(lkp_ready),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .fill_data_i(fill_data),
    .rsp_valid_o(rsp_valid), .rsp_src_o(rsp_src), .rsp_data_o(rsp_data),
    .nl_req_o(nl_req), .nl_addr_o(nl_addr), .nl_gnt_i(nl_gnt),
    .nl_rsp_valid_i(nl_rv), .nl_rsp_data_i(nl_rd)
  );

  function automatic logic [DW-1:0] nl_fn(input logic [AW-1:0] a);
    return {6'h2A, a, 6'h15, a};
  endfunction

  function automatic logic [DW-1:0] fd(input logic [AW-1:0] a, input logic [5:0] v);
    return {6'h3C, a, v, a};
  endfunction

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // driver: one cycle of lookup and/or fill, expected results pushed to the scoreboard
  task automatic op(input logic lv, input logic [AW-1:0] la,
                    input logic fv, input logic [AW-1:0] fa, input logic [DW-1:0] fdat,
                    input logic exp_hit, input logic [DW-1:0] exp_d, input string r);
    while (!lkp_ready) @(negedge clk);
    lkp_valid  = lv;
    lkp_addr   = la;
    fill_valid = fv;
    fill_addr  = fa;
    fill_data  = fdat;
    if (lv) begin
      if (exp_hit) begin
        exp_q.push_back({1'b0, exp_d});
        tag_q.push_back(r);
      end else begin
        exp_q.push_back({1'b1, nl_fn(la)});
        tag_q.push_back({r, " R6"});
      end
    end
    @(negedge clk);
    lkp_valid  = 1'b0;
    fill_valid = 1'b0;
    if (lv && !exp_hit) begin
      chk({r, " R5 req"}, DW'(nl_req), DW'(1));
      chk({r, " R5 addr"}, DW'(nl_addr), DW'(la));
      chk({r, " R5 ready"}, DW'(lkp_ready), DW'(0));
    end else if (lv) begin
      chk({r, " R2 no req"}, DW'(nl_req), DW'(0));
    end
  endtask

  // monitor: compare returned lines against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R2 unexpected rsp act %h exp none", rsp_data);
        end else begin
          logic [DW:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " src"}, DW'(rsp_src), DW'(e[DW]));
          chk({t, " data"}, rsp_data, e[DW-1:0]);
        end
      end
    end
  end

  // next-level model: grant after two cycles, respond two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && nl_req) begin
        logic [AW-1:0] a;
        a = nl_addr;
        @(negedge clk);
        chk("R5 hold req", DW'(nl_req), DW'(1));
        chk("R5 hold addr", DW'(nl_addr), DW'(a));
        nl_gnt = 1'b1;
        @(negedge clk);
        nl_gnt = 1'b0;
        chk("R5 req drop", DW'(nl_req), DW'(0));
        @(negedge clk);
        nl_rv = 1'b1;
        nl_rd = nl_fn(a);
        @(negedge clk);
        nl_rv = 1'b0;
        chk("R6 ready back", DW'(lkp_ready), DW'(1));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog act hung exp done");
    summary();
    $finish;
  end

  localparam logic [AW-1:0] A = 26'h21, B = 26'h22, C = 26'h23, D = 26'h24;
  localparam logic [AW-1:0] E = 26'h25, G = 26'h30, H = 26'h31, X = 26'h40;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", DW'(lkp_ready), DW'(1));
    chk("R1 req in reset", DW'(nl_req), DW'(0));
    chk("R1 rsp in reset", DW'(rsp_valid), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", DW'(lkp_ready), DW'(1));
    chk("R1 rsp", DW'(rsp_valid), DW'(0));

    op(1'b1, 26'h10, 1'b0, '0, '0, 1'b0, '0, "R1 empty miss");
    // fill four lines into the empty buffer
    op(1'b0, '0, 1'b1, A, fd(A, 6'd1), 1'b0, '0, "R7");
    op(1'b0, '0, 1'b1, B, fd(B, 6'd1), 1'b0, '0, "R7");
    op(1'b0, '0, 1'b1, C, fd(C, 6'd1), 1'b0, '0, "R7");
    op(1'b0, '0, 1'b1, D, fd(D, 6'd1), 1'b0, '0, "R7");
    // rewrite A in place: A becomes newest, B oldest
    op(1'b0, '0, 1'b1, A, fd(A, 6'd2), 1'b0, '0, "R9");
    // full buffer: E must replace B
    op(1'b0, '0, 1'b1, E, fd(E, 6'd1), 1'b0, '0, "R8");
    op(1'b1, B, 1'b0, '0, '0, 1'b0, '0, "R8 oldest evicted");
    // swap: A hits, G takes its entry
    op(1'b1, A, 1'b1, G, fd(G, 6'd1), 1'b1, fd(A, 6'd2), "R9 R3 swap hit");
    op(1'b1, G, 1'b0, '0, '0, 1'b1, fd(G, 6'd1), "R3 swapped-in line");
    op(1'b1, G, 1'b0, '0, '0, 1'b0, '0, "R4 freed");
    op(1'b1, A, 1'b0, '0, '0, 1'b0, '0, "R3 swapped-out line");
    // one free entry: H must not evict C, D or E
    op(1'b0, '0, 1'b1, H, fd(H, 6'd1), 1'b0, '0, "R7");
    op(1'b1, C, 1'b0, '0, '0, 1'b1, fd(C, 6'd1), "R7 kept C");
    op(1'b1, D, 1'b0, '0, '0, 1'b1, fd(D, 6'd1), "R7 kept D");
    op(1'b1, E, 1'b0, '0, '0, 1'b1, fd(E, 6'd1), "R8 kept E");
    op(1'b1, H, 1'b0, '0, '0, 1'b1, fd(H, 6'd1), "R7 stored H");
    // same address in the same cycle
    op(1'b1, X, 1'b1, X, fd(X, 6'd1), 1'b1, fd(X, 6'd1), "R10 fill wins");
    op(1'b1, X, 1'b0, '0, '0, 1'b0, '0, "R10 not kept");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 idle at end", DW'(lkp_ready), DW'(1));
    summary();
    $finish;
  end
endmodule